// File: doc/BRIEF.md
# GPIO Controller with Interrupt Detection

This block drives and senses sixteen general-purpose pins on behalf of software that reaches it over a simple 32-bit memory-mapped register bus. Software writes an output value and a per-line direction. It reads back the pin levels after they have passed a two-flop synchronizer. A direction bit of 1 makes the line an input and releases its driver. A direction bit of 0 drives the stored output value onto the pin.

Each line has an interrupt detector. A 3-bit trigger code selects how the detector reacts to the synchronized level:

| Code | Trigger |
|------|---------|
| 0 | level high |
| 1 | level low |
| 2 | rising edge |
| 3 | falling edge |
| 4 | any transition |
| 5 to 7 | reserved, never trigger |

A trigger sets a sticky status bit. Software clears a status bit by writing 1 to it. Lines 0 to 12 each drive an active-high interrupt output toward a parent interrupt controller. That output is high for as long as the line's status bit is set. Lines 13 to 15 still latch status, but they have no interrupt output.

Two further registers are plain storage. They hold a clock-select word and a debounce-select word, which software can write and read back. Neither has any effect on the pins.

Register map. Word offsets are fixed. The address bits [1:0] are ignored.

| Offset | Register | Access | Contents |
|--------|----------|--------|----------|
| 0x00 | output data | read/write | bits [15:0] |
| 0x04 | direction | read/write | bits [15:0], 1 = input |
| 0x08 | input level | read-only | bits [15:0], synchronized pin levels |
| 0x0C | status | write 1 to clear | bits [15:0] |
| 0x10 | trigger codes, lines 0 to 7 | read/write | bits [23:0] |
| 0x14 | trigger codes, lines 8 to 15 | read/write | bits [23:0] |
| 0x18 | clock-select store | read/write | bits [31:0] |
| 0x1C | debounce-select store | read/write | bits [31:0] |

Register behaviour:
- Line n uses bits [3*(n mod 8)+2 : 3*(n mod 8)] of its trigger register. Bits [31:24] of both trigger registers read 0.
- All registers not listed as 32-bit read 0 above bit 15.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted and immediately after it:
  - the output data register is 0 and the direction register is 0xFFFF, so `pin_oe` is 0;
  - the status register, both trigger registers and both store registers are 0;
  - `irq_out` is 0.
- R2: `pin_out` equals the output data register (offset 0x00). `pin_oe[n]` is the inverse of direction bit n (offset 0x04). Both registers read back what was last written, and a write shows on the pins from the clock edge that accepts it.
- R3: Offset 0x08 reads the pin levels through a two-flop synchronizer. Suppose a pin changes between two clock edges. A read after the next edge still returns the old level, and a read after the second edge returns the new level.
- R4: The trigger code of line n lies in bits [3*(n mod 8)+2 : 3*(n mod 8)]. Lines 0 to 7 use the register at 0x10, and lines 8 to 15 use the register at 0x14. Bits [31:24] of both registers read 0 even after a write of all ones.
- R5: Code 0 (level high) and code 1 (level low) set the status bit on every cycle that the synchronized level matches. A clear therefore has no lasting effect while that level holds, and the bit stays set once the level goes away.
- R6: Code 2 sets the status bit on a rising edge of the synchronized level, and code 3 sets it on a falling edge. The status becomes visible after the third clock edge that follows the pin change. It then stays set until cleared.
- R7: Code 4 sets the status bit on both rising and falling edges.
- R8: Codes 5, 6 and 7 never set the status bit, whatever the pin does.
- R9: Writing to the status register clears each bit written as 1 and leaves each bit written as 0 unchanged. A trigger in the same cycle as a clear wins, and the bit stays set.
- R10: `irq_out[n]` equals status bit n for lines 0 to 12. Lines 13 to 15 have no interrupt output, but their status bits can still be read at 0x0C.
- R11: The registers at 0x18 and 0x1C store all 32 bits written and read them back. Writing them changes neither `pin_out`, `pin_oe` nor the status register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_en | input | 1 | register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | byte address; bits [4:2] select the register |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, combinational from `bus_addr` |
| pin_in | input | 16 | pin levels, asynchronous to `clk` |
| pin_out | output | 16 | output data driven onto the pins |
| pin_oe | output | 16 | per-line output driver enable, 1 = driving |
| irq_out | output | 13 | active-high interrupt level per line 0 to 12 |

## Verification
The checker assumes four things about the bus:
- each write is a single-cycle strobe whose address and data are stable across the accepting clock edge;
- `bus_addr` always selects one of the eight word offsets;
- no write to the status register arrives while a detector would set that bit, except where the set-over-clear rule is being exercised;
- `pin_in` changes only once the synchronizer has been allowed to settle.

The stimulus keeps within these assumptions in the following ways:
- it changes `pin_in` and the bus signals only at falling clock edges, and raises the write strobe for exactly one rising edge;
- it holds every pin other than the line under test at 0, with that line's trigger code at 0, so that no other line triggers;
- it waits at least three edges after each pin change before it reads status, which matches the stated latency of synchronizer plus detector.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int TRIG_W = 3;

    typedef enum logic [TRIG_W-1:0] {
        TRIG_HIGH = 3'd0,
        TRIG_LOW  = 3'd1,
        TRIG_RISE = 3'd2,
        TRIG_FALL = 3'd3,
        TRIG_ANY  = 3'd4
    } trig_style_e;

    typedef enum logic [2:0] {
        REG_DOUT    = 3'd0,
        REG_DIR     = 3'd1,
        REG_DIN     = 3'd2,
        REG_STAT    = 3'd3,
        REG_TRIG_LO = 3'd4,
        REG_TRIG_HI = 3'd5,
        REG_CKSEL   = 3'd6,
        REG_DBSEL   = 3'd7
    } reg_idx_e;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] now_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] now_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            now_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_i;
            now_q  <= meta_q;
            prev_q <= now_q;
        end
    end

    assign now_o  = now_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/gpio_line_detect.sv
module gpio_line_detect
    import gpio_irq_pkg::*;
(
    input  logic              now_i,
    input  logic              prev_i,
    input  logic [TRIG_W-1:0] style_i,
    output logic              hit_o
);
    always_comb begin
        hit_o = 1'b0;
        unique case (style_i)
            TRIG_HIGH: hit_o = now_i;
            TRIG_LOW:  hit_o = ~now_i;
            TRIG_RISE: hit_o = now_i & ~prev_i;
            TRIG_FALL: hit_o = ~now_i & prev_i;
            TRIG_ANY:  hit_o = now_i ^ prev_i;
            default:   hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NLINES        = 16,
    parameter int NIRQ          = 13,
    parameter int LINES_PER_REG = 8,
    parameter int DW            = 32,
    parameter int AW            = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NLINES-1:0] pin_in,
    output logic [NLINES-1:0] pin_out,
    output logic [NLINES-1:0] pin_oe,
    output logic [NIRQ-1:0]   irq_out
);
    localparam int NTRIG   = (NLINES + LINES_PER_REG - 1) / LINES_PER_REG;
    localparam int FIELD_W = TRIG_W * LINES_PER_REG;

    logic [NLINES-1:0]  dout_q;
    logic [NLINES-1:0]  dir_q;
    logic [NLINES-1:0]  stat_q;
    logic [FIELD_W-1:0] trig_q [NTRIG];
    logic [DW-1:0]      cksel_q;
    logic [DW-1:0]      dbsel_q;

    logic [NLINES-1:0]  s_now;
    logic [NLINES-1:0]  s_prev;
    logic [NLINES-1:0]  hit;
    logic [NLINES-1:0]  clr_mask;
    logic               wr;
    reg_idx_e           idx;
    logic               unused_addr_lsb;

    assign wr              = bus_en & bus_we;
    assign idx             = reg_idx_e'(bus_addr[AW-1:2]);
    assign unused_addr_lsb = ^bus_addr[1:0];

    gpio_pin_sync #(.W(NLINES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_in),
        .now_o  (s_now),
        .prev_o (s_prev)
    );

    for (genvar n = 0; n < NLINES; n++) begin : g_line
        logic [TRIG_W-1:0] sty;
        assign sty = trig_q[n / LINES_PER_REG][TRIG_W*(n % LINES_PER_REG) +: TRIG_W];
        gpio_line_detect u_det (
            .now_i   (s_now[n]),
            .prev_i  (s_prev[n]),
            .style_i (sty),
            .hit_o   (hit[n])
        );
    end

    // configuration register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q  <= '0;
            dir_q   <= '1;
            cksel_q <= '0;
            dbsel_q <= '0;
            for (int k = 0; k < NTRIG; k++) trig_q[k] <= '0;
        end else if (wr) begin
            unique case (idx)
                REG_DOUT:    dout_q          <= bus_wdata[NLINES-1:0];
                REG_DIR:     dir_q           <= bus_wdata[NLINES-1:0];
                REG_TRIG_LO: trig_q[0]       <= bus_wdata[FIELD_W-1:0];
                REG_TRIG_HI: trig_q[NTRIG-1] <= bus_wdata[FIELD_W-1:0];
                REG_CKSEL:   cksel_q         <= bus_wdata;
                REG_DBSEL:   dbsel_q         <= bus_wdata;
                REG_DIN, REG_STAT: ;
            endcase
        end
    end

    // sticky status: set wins over write-one-to-clear
    assign clr_mask = (wr && idx == REG_STAT) ? bus_wdata[NLINES-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | hit;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (idx)
            REG_DOUT:    bus_rdata = DW'(dout_q);
            REG_DIR:     bus_rdata = DW'(dir_q);
            REG_DIN:     bus_rdata = DW'(s_now);
            REG_STAT:    bus_rdata = DW'(stat_q);
            REG_TRIG_LO: bus_rdata = DW'(trig_q[0]);
            REG_TRIG_HI: bus_rdata = DW'(trig_q[NTRIG-1]);
            REG_CKSEL:   bus_rdata = cksel_q;
            REG_DBSEL:   bus_rdata = dbsel_q;
        endcase
    end

    assign pin_out = dout_q;
    assign pin_oe  = ~dir_q;
    assign irq_out = stat_q[NIRQ-1:0];
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
    parameter int NLINES = 16,
    parameter int NIRQ   = 13,
    parameter int DW     = 32,
    parameter int AW     = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_en,
    input logic              bus_we,
    input logic [AW-1:0]     bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic [NLINES-1:0] pin_out,
    input logic [NLINES-1:0] pin_oe,
    input logic [NIRQ-1:0]   irq_out
);
    logic            wr_out;
    logic            wr_dir;
    logic            wr_stat;
    logic [NIRQ-1:0] keep;
    logic            unused_chk;

    assign wr_out     = bus_en && bus_we && bus_addr[AW-1:2] == 3'd0;
    assign wr_dir     = bus_en && bus_we && bus_addr[AW-1:2] == 3'd1;
    assign wr_stat    = bus_en && bus_we && bus_addr[AW-1:2] == 3'd3;
    assign keep       = wr_stat ? (irq_out & ~bus_wdata[NIRQ-1:0]) : irq_out;
    assign unused_chk = ^{bus_addr[1:0], bus_wdata[DW-1:NLINES]};

    // R1: quiet outputs during reset
    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (pin_oe == '0 && pin_out == '0 && irq_out == '0)
                else $error("reset outputs not quiet");
        end
    end

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> pin_oe == ~$past(bus_wdata[NLINES-1:0]))
        else $error("pin_oe does not follow direction write");

    p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(pin_oe))
        else $error("pin_oe changed without direction write");

    p_dout_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_out |=> pin_out == $past(bus_wdata[NLINES-1:0]))
        else $error("pin_out does not follow data write");

    p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((irq_out & $past(keep)) == $past(keep)))
        else $error("interrupt dropped without a clear");
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
    .NLINES (NLINES),
    .NIRQ   (NIRQ),
    .DW     (DW),
    .AW     (AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq_out   (irq_out)
);

// File: tb/sim_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_irq_ctrl;
    localparam logic [4:0] A_DOUT = 5'h00, A_DIR = 5'h04, A_DIN = 5'h08, A_STAT = 5'h0C;
    localparam logic [4:0] A_TLO = 5'h10, A_THI = 5'h14, A_CK = 5'h18, A_DB = 5'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic [12:0] irq_out;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    gpio_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic string tag_of(input int c);
        if (c <= 1) return "R5";
        else if (c <= 3) return "R6";
        else if (c == 4) return "R7";
        else return "R8";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", tests, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] exp;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_DOUT, d); check("R1 dout", d, 32'h0);
        rd(A_DIR, d);  check("R1 dir", d, 32'h0000FFFF);
        rd(A_STAT, d); check("R1 status", d, 32'h0);
        rd(A_TLO, d);  check("R1 trig lo", d, 32'h0);
        rd(A_THI, d);  check("R1 trig hi", d, 32'h0);
        rd(A_CK, d);   check("R1 cksel", d, 32'h0);
        rd(A_DB, d);   check("R1 dbsel", d, 32'h0);
        check("R1 pin_oe", 32'(pin_oe), 32'h0);
        check("R1 irq_out", 32'(irq_out), 32'h0);

        // R2 output data and direction
        wr(A_DOUT, 32'hFFFFA5C3);
        wr(A_DIR, 32'h00000F0F);
        rd(A_DOUT, d); check("R2 dout readback", d, 32'h0000A5C3);
        rd(A_DIR, d);  check("R2 dir readback", d, 32'h00000F0F);
        check("R2 pin_out", 32'(pin_out), 32'h0000A5C3);
        check("R2 pin_oe", 32'(pin_oe), 32'h0000F0F0);

        // R11 store registers
        wr(A_CK, 32'hDEADBEEF);
        wr(A_DB, 32'h12345678);
        rd(A_CK, d); check("R11 cksel", d, 32'hDEADBEEF);
        rd(A_DB, d); check("R11 dbsel", d, 32'h12345678);
        check("R11 pin_out kept", 32'(pin_out), 32'h0000A5C3);
        check("R11 pin_oe kept", 32'(pin_oe), 32'h0000F0F0);
        rd(A_STAT, d); check("R11 status kept", d, 32'h0);
        wr(A_DIR, 32'h0000FFFF);

        // R4 upper bits of the trigger registers
        wr(A_TLO, 32'hFFFFFFFF);
        rd(A_TLO, d); check("R4 trig lo width", d, 32'h00FFFFFF);
        wr(A_THI, 32'hFFFFFFFF);
        rd(A_THI, d); check("R4 trig hi width", d, 32'h00FFFFFF);
        wr(A_TLO, 32'h0);
        wr(A_THI, 32'h0);

        // R3 synchronizer latency
        @(negedge clk); pin_in = 16'h8001;
        @(posedge clk);
        rd(A_DIN, d); check("R3 one edge old", d, 32'h0);
        @(posedge clk);
        rd(A_DIN, d); check("R3 two edges new", d, 32'h00008001);
        @(negedge clk); pin_in = 16'h0;
        repeat (4) @(posedge clk);
        wr(A_STAT, 32'h0000FFFF);

        // sweep every line and every trigger code
        for (int n = 0; n < 16; n++) begin
            for (int c = 0; c < 8; c++) begin
                logic [31:0] field;
                logic [4:0]  ta;
                logic [31:0] bit_n;
                logic        s_lo, s_rise, s_clr1, s_fall, s_clr2;
                string       t;
                t     = tag_of(c);
                field = 32'(c) << (3 * (n % 8));
                ta    = (n < 8) ? A_TLO : A_THI;
                bit_n = 32'h1 << n;
                wr(A_TLO, (n < 8) ? field : 32'h0);
                wr(A_THI, (n < 8) ? 32'h0 : field);
                rd(ta, d); check("R4 field placement", d, field);
                wr(A_STAT, 32'h0000FFFF);
                repeat (2) @(posedge clk);
                s_lo = (c == 1);
                rd(A_STAT, d); check({t, " idle low"}, d, s_lo ? bit_n : 32'h0);

                @(negedge clk); pin_in[n] = 1'b1;
                repeat (3) @(posedge clk);
                s_rise = s_lo | (c == 0) | (c == 2) | (c == 4);
                exp = s_rise ? bit_n : 32'h0;
                rd(A_STAT, d); check({t, " after rise"}, d, exp);
                check("R10 irq after rise", 32'(irq_out), exp & 32'h1FFF);
                wr(A_STAT, 32'h0);
                rd(A_STAT, d); check("R9 write zero keeps", d, exp);

                wr(A_STAT, 32'h0000FFFF);
                s_clr1 = (c == 0);
                rd(A_STAT, d); check({t, " clear while high (R9)"}, d, s_clr1 ? bit_n : 32'h0);

                @(negedge clk); pin_in[n] = 1'b0;
                repeat (3) @(posedge clk);
                s_fall = s_clr1 | (c == 1) | (c == 3) | (c == 4);
                exp = s_fall ? bit_n : 32'h0;
                rd(A_STAT, d); check({t, " after fall"}, d, exp);
                check("R10 irq after fall", 32'(irq_out), exp & 32'h1FFF);

                wr(A_STAT, 32'h0000FFFF);
                s_clr2 = (c == 1);
                rd(A_STAT, d); check({t, " clear while low (R9)"}, d, s_clr2 ? bit_n : 32'h0);
            end
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule